// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block finds the highest-priority request among a set of active-low request lines and reports its position. The basic unit is an eight-line stage. A request line is asserted when it is driven low, and line 7 has the highest priority. The stage reports the winning line on a three-bit code that is also active-low, so the code is the bitwise complement of the binary line number. The stage works only while its active-low enable is asserted. It has two status pins. A group-select pin goes low when the stage has found a request. A pass-down pin goes low when the stage is enabled but has no request, which hands the decision to the next stage down.

The top level chains four stages into a 32-line encoder. The highest stage is always enabled. Each stage's pass-down pin enables the stage below it, so at most one stage can be active at any time. The two upper bits of the result come from which stage raised group-select. The three lower bits are the AND of all stage codes, inverted. This works because an inactive stage drives its code to all ones. The output index is active-high, with a valid flag beside it. The whole block is combinational.

Top module: `prio32_chain`

## Requirements
- R1: An enabled stage with at least one request low drives its code with the complement of the highest-numbered low request line (line 7 wins over line 0). For example, line 5 gives code 3'b010.
- R2: A stage whose enable is high drives code 3'b111, group-select high and pass-down high, whatever its request lines are.
- R3: A stage's group-select is low exactly when its enable is low and at least one of its request lines is low.
- R4: A stage's pass-down is low exactly when its enable is low and all of its request lines are high.
- R5: Group-select and pass-down of a stage are never both low.
- R6: In the 32-line chain, bit 31 of the request vector has the highest priority. The index output equals the bit number of the highest low bit in the request vector.
- R7: The chain's valid flag is 1 exactly when at least one request bit is low. When valid is 0, the index reads 0.
- R8: A request in a higher stage overrides any request in a lower stage. Requests on lines 31 and 0 together give index 31, and requests on lines 8 and 7 together give index 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 32 | Active-low request lines; bit 31 has the highest priority |
| idx | output | 5 | Bit number of the highest asserted request, active-high |
| valid | output | 1 | High when any request line is asserted |

## Verification
The hardest situation to reach from the chain's ports is a lower stage that holds a request while a higher stage also wins. In that case the lower stage's own code must stay hidden behind the enable chain. Random 32-bit vectors almost always set a bit in the top stage, so the lower stages rarely take part. The stimulus therefore adds directed pairs that straddle each stage boundary, plus single-bit walks. Every enable and request combination of one stage is driven exhaustively on a separate stage instance.

// File: rtl/prio_pkg.sv
package prio_pkg;
  // Width of an index into n items, never below one bit.
  function automatic int min_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_stage.sv
module prio_stage #(
  parameter int W  = 8,
  localparam int IW = prio_pkg::min_width(W)
) (
  input  logic          en_n,
  input  logic [W-1:0]  req_n,
  output logic [IW-1:0] code_n,
  output logic          grp_n,
  output logic          pass_n
);
  // Highest set bit of an active-high vector; the ascending loop lets the top bit win.
  function automatic logic [IW-1:0] top_index(input logic [W-1:0] act);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (act[i]) r = IW'(i);
    end
    return r;
  endfunction

  logic          enabled;
  logic          any_req;
  logic          hit;
  logic [IW-1:0] win_idx;

  assign enabled = ~en_n;
  assign any_req = ~&req_n;
  assign hit     = enabled & any_req;
  assign win_idx = top_index(~req_n);

  assign code_n = hit ? ~win_idx : '1;
  assign grp_n  = ~hit;
  assign pass_n = ~(enabled & ~any_req);
endmodule

// File: rtl/prio_grp_enc.sv
module prio_grp_enc #(
  parameter int N  = 4,
  localparam int SW = prio_pkg::min_width(N)
) (
  input  logic [N-1:0]  grp_n,
  output logic [SW-1:0] sel
);
  // Number of the stage whose group-select is low; only one can be low at a time.
  always_comb begin
    sel = '0;
    for (int s = 0; s < N; s++) begin
      if (!grp_n[s]) sel = SW'(s);
    end
  end
endmodule

// File: rtl/prio32_chain.sv
module prio32_chain #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 8,
  localparam int CODE_W = prio_pkg::min_width(STAGE_W),
  localparam int SEL_W  = prio_pkg::min_width(NUM_STAGES),
  localparam int IDX_W  = CODE_W + SEL_W,
  localparam int REQ_W  = NUM_STAGES * STAGE_W
) (
  input  logic [REQ_W-1:0] req_n,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  // Named stage signals, brought out for the checker.
  logic [NUM_STAGES-1:0]             en_n_w;
  logic [NUM_STAGES-1:0]             grp_n_w;
  logic [NUM_STAGES-1:0]             pass_n_w;
  logic [NUM_STAGES-1:0][CODE_W-1:0] code_n_w;
  logic [CODE_W-1:0]                 code_and;
  logic [SEL_W-1:0]                  stage_sel;

  // The top stage is always enabled; each pass-down enables the next stage down.
  assign en_n_w[NUM_STAGES-1] = 1'b0;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s < NUM_STAGES - 1) begin : g_link
      assign en_n_w[s] = pass_n_w[s+1];
    end
    prio_stage #(.W(STAGE_W)) stage_i (
      .en_n   (en_n_w[s]),
      .req_n  (req_n[s*STAGE_W +: STAGE_W]),
      .code_n (code_n_w[s]),
      .grp_n  (grp_n_w[s]),
      .pass_n (pass_n_w[s])
    );
  end

  prio_grp_enc #(.N(NUM_STAGES)) grp_enc_i (
    .grp_n (grp_n_w),
    .sel   (stage_sel)
  );

  // Inactive stages drive all ones, so the AND keeps only the active stage's code.
  always_comb begin
    code_and = '1;
    for (int s = 0; s < NUM_STAGES; s++) begin
      code_and &= code_n_w[s];
    end
  end

  assign idx   = {stage_sel, ~code_and};
  // The lowest stage passes down only when no stage found a request.
  assign valid = pass_n_w[0];
endmodule

// File: rtl/prio32_chain_chk.sv
module prio32_chain_chk #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 8,
  localparam int CODE_W = prio_pkg::min_width(STAGE_W),
  localparam int SEL_W  = prio_pkg::min_width(NUM_STAGES),
  localparam int IDX_W  = CODE_W + SEL_W,
  localparam int REQ_W  = NUM_STAGES * STAGE_W
) (
  input logic [REQ_W-1:0]                  req_n,
  input logic [IDX_W-1:0]                  idx,
  input logic                              valid,
  input logic [NUM_STAGES-1:0]             en_n_w,
  input logic [NUM_STAGES-1:0]             grp_n_w,
  input logic [NUM_STAGES-1:0]             pass_n_w,
  input logic [NUM_STAGES-1:0][CODE_W-1:0] code_n_w
);
  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      // R5
      grp_pass_excl_chk: assert (grp_n_w[s] || pass_n_w[s])
        else $error("stage %0d group-select and pass-down both low", s);
      // R2
      idle_stage_chk: assert (!en_n_w[s] || (grp_n_w[s] && pass_n_w[s] && (&code_n_w[s])))
        else $error("disabled stage %0d not idle", s);
    end
    // R6
    one_group_chk: assert ($onehot0(~grp_n_w))
      else $error("more than one stage active");
    // R7
    valid_match_chk: assert (valid == ~&req_n)
      else $error("valid does not follow requests");
    // R7
    idle_idx_chk: assert (valid || idx == '0)
      else $error("index nonzero while not valid");
    // R6
    won_req_chk: assert (!valid || !req_n[idx])
      else $error("reported index %0d not requested", idx);
    for (int j = 0; j < REQ_W; j++) begin
      // R8
      higher_idle_chk: assert (!valid || j <= int'(idx) || req_n[j])
        else $error("bit %0d above index %0d is requested", j, idx);
    end
  end
endmodule

bind prio32_chain prio32_chain_chk chk_i (
  .req_n    (req_n),
  .idx      (idx),
  .valid    (valid),
  .en_n_w   (en_n_w),
  .grp_n_w  (grp_n_w),
  .pass_n_w (pass_n_w),
  .code_n_w (code_n_w)
);

// File: tb/prio32_chain_tb_top.sv
module prio32_chain_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5ns clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // Single stage under exhaustive test
  logic       s_en_n  = 1'b1;
  logic [7:0] s_req_n = 8'hFF;
  logic [2:0] s_code_n;
  logic       s_grp_n, s_pass_n;

  // Full chain
  logic [31:0] c_req_n = '1;
  logic [4:0]  c_idx;
  logic        c_valid;

  prio_stage #(.W(8)) stage_i (
    .en_n(s_en_n), .req_n(s_req_n), .code_n(s_code_n),
    .grp_n(s_grp_n), .pass_n(s_pass_n)
  );

  prio32_chain dut_i (.req_n(c_req_n), .idx(c_idx), .valid(c_valid));

  typedef struct {
    bit         is_chain;
    logic [2:0] code;
    logic       grp;
    logic       pass;
    logic [4:0] idx;
    logic       vld;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic drive_stage(input logic en_n, input logic [7:0] req_n);
    exp_t e;
    bit found = 1'b0;
    int win = 0;
    for (int i = 7; i >= 0; i--) begin
      if (!found && !req_n[i]) begin found = 1'b1; win = i; end
    end
    e.is_chain = 1'b0;
    e.code = (!en_n && found) ? ~3'(win) : 3'b111;
    e.grp  = !(!en_n && found);
    e.pass = !(!en_n && !found);
    e.idx  = '0;
    e.vld  = 1'b0;
    e.tag  = en_n ? "R2" : (found ? "R1 R3" : "R4");
    @(posedge clk);
    s_en_n  = en_n;
    s_req_n = req_n;
    exp_q.push_back(e);
  endtask

  task automatic drive_chain(input logic [31:0] req_n, input string tag);
    exp_t e;
    bit found = 1'b0;
    int win = 0;
    for (int i = 31; i >= 0; i--) begin
      if (!found && !req_n[i]) begin found = 1'b1; win = i; end
    end
    e.is_chain = 1'b1;
    e.code = '0; e.grp = 1'b0; e.pass = 1'b0;
    e.idx  = found ? 5'(win) : 5'd0;
    e.vld  = found;
    e.tag  = tag;
    @(posedge clk);
    c_req_n = req_n;
    exp_q.push_back(e);
  endtask

  // Monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.is_chain) begin
        n_checks++;
        if (c_idx !== e.idx || c_valid !== e.vld) begin
          n_errors++;
          $display("FAIL %s req_n=%h idx/valid actual=%0d/%0b expected=%0d/%0b",
                   e.tag, c_req_n, c_idx, c_valid, e.idx, e.vld);
        end
      end else begin
        n_checks++;
        if (s_code_n !== e.code || s_grp_n !== e.grp || s_pass_n !== e.pass) begin
          n_errors++;
          $display("FAIL %s en_n=%b req_n=%b code/grp/pass actual=%b/%b/%b expected=%b/%b/%b",
                   e.tag, s_en_n, s_req_n, s_code_n, s_grp_n, s_pass_n,
                   e.code, e.grp, e.pass);
        end
        n_checks++;
        if (!s_grp_n && !s_pass_n) begin
          n_errors++;
          $display("FAIL R5 grp/pass actual=%b/%b expected not both 0", s_grp_n, s_pass_n);
        end
      end
    end
  end

  initial begin
    #2_000_000ns;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: idle inputs give idle outputs (R2, R7)
    drive_stage(1'b1, 8'hFF);
    drive_chain('1, "R7");
    // Exhaustive stage sweep (R1 R2 R3 R4 R5)
    for (int en = 0; en < 2; en++) begin
      for (int v = 0; v < 256; v++) drive_stage(1'(en), 8'(v));
    end
    // Walking single requests (R6)
    for (int i = 0; i < 32; i++) drive_chain(~(32'd1 << i), "R6");
    // All asserted, none asserted (R6, R7)
    drive_chain('0, "R6");
    drive_chain('1, "R7");
    // Stage boundary overrides (R8)
    drive_chain(~(32'h8000_0001), "R8");
    drive_chain(~(32'h0000_0180), "R8");
    drive_chain(~(32'h0180_0000), "R8");
    drive_chain(~(32'h0001_8000), "R8");
    // Lower stages only, top stages idle (R6 R8)
    for (int k = 0; k < 64; k++) begin
      r = $urandom;
      drive_chain(~(r >> ((k % 4) * 8 + 1)), "R6");
    end
    // Random vectors (R6)
    for (int k = 0; k < 150; k++) begin
      r = $urandom;
      drive_chain(r, "R6");
    end
    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule